// File: doc/BRIEF.md
# Dual-Issue Unit Reservation Checker

This block sits after decode in an in-order pipeline that can start two instructions per cycle. Each cycle it receives the class codes of the older and the younger instruction at the head of the queue. It decides whether only the older one, both, or neither may start this cycle. It models four issue resources: unit A, unit B, unit C and an ALU port. For each instruction that starts, it reports the unit mask that was chosen for it.

Every class has one or two allowed unit combinations, and the block tries them in a fixed order. The older instruction is placed first. The younger one may only use the units the older one left free. Some classes hold units in later cycles as well: long multiplies, multi-word memory accesses and divides. A per-unit future-busy shift register records those later claims. An instruction whose units are claimed in any cycle it needs does not start, and it is offered again by the caller.

Top module: `dual_issue_check`

Unit mask encoding, used on both map outputs: bit 0 = A, bit 1 = B, bit 2 = C, bit 3 = ALU.

Class codes:

| Code | Class |
|------|-------|
| 0 | plain ALU |
| 1 | ALU with register shift |
| 2 | move |
| 3 | short multiply |
| 4 | long multiply |
| 5 | unsigned divide |
| 6 | signed divide |
| 7 | single load/store |
| 8 | multi-word load/store |
| 9 | branch |
| 10 to 15 | need no unit |

## Requirements
- R1: After reset, no unit is reserved. While both valid inputs are low, both issue outputs and both maps are 0.
- R2: Class 0 takes A+ALU (4'b1001) when both units are free, and otherwise B+ALU (4'b1010).
- R3: Class 1 takes A+ALU (4'b1001) when both units are free, and otherwise B+C+ALU (4'b1110).
- R4: Class 2 takes A alone (4'b0001) when A is free, and otherwise B+ALU (4'b1010).
- R5: Class 3 holds A+ALU in its issue cycle only. Class 4 holds A+ALU in its issue cycle and in the next cycle.
- R6: Class 5 holds A+ALU in its issue cycle and again UDIV_GAP+1 cycles later (default 8). Class 6 does the same SDIV_GAP+1 cycles later (default 9). Between those two cycles, A and ALU stay free for other instructions.
- R7: Class 7 takes A+C (4'b0101). Class 8 holds A+B (4'b0011) in its issue cycle and in the next cycle.
- R8: Class 9 takes B alone (4'b0010). Codes 10 to 15 take no unit, and they issue whenever they are offered.
- R9: The younger instruction never issues if the older one does not issue, or if yng_dep_i is high, or if the older one is class 2 and the younger one is class 0.
- R10: The older instruction is placed first. The younger one uses only units left free by the older one and by earlier reservations. The two maps never share a unit.
- R11: An instruction whose units are claimed by an earlier reservation in any cycle it needs does not issue, and its map is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| old_valid_i | input | 1 | older slot holds an instruction |
| old_cls_i | input | 4 | class code of the older instruction |
| yng_valid_i | input | 1 | younger slot holds an instruction |
| yng_cls_i | input | 4 | class code of the younger instruction |
| yng_dep_i | input | 1 | younger instruction needs the older one's result |
| issue_old_o | output | 1 | older instruction starts this cycle |
| issue_yng_o | output | 1 | younger instruction starts this cycle |
| old_map_o | output | 4 | units taken by the older instruction this cycle |
| yng_map_o | output | 4 | units taken by the younger instruction this cycle |

## Verification
The directed pairs are chosen so that each one separates one decision from the others:
- Pairs where the older instruction takes A show whether the younger one falls back to its second choice.
- Pairs where both need the ALU show whether a conflict is detected.
- The dependency pair and the move-then-ALU pair show the pairing bans.
- Long multiplies, multi-word accesses and divides, followed by a run of single-cycle instructions, separate a hold in the next cycle from a hold in the final divide cycle. They also show the free gap in between.

A long stream of mixed classes then checks the combined effect of the reservations against a behavioural model, every cycle.

// File: rtl/dual_issue_pkg.sv
package dual_issue_pkg;

  localparam int NUM_UNITS = 4;

  localparam logic [NUM_UNITS-1:0] M_A   = 4'b0001;
  localparam logic [NUM_UNITS-1:0] M_B   = 4'b0010;
  localparam logic [NUM_UNITS-1:0] M_C   = 4'b0100;
  localparam logic [NUM_UNITS-1:0] M_ALU = 4'b1000;

  typedef enum logic [3:0] {
    CLS_ALU      = 4'd0,
    CLS_ALU_SREG = 4'd1,
    CLS_MOV      = 4'd2,
    CLS_MUL_S    = 4'd3,
    CLS_MUL_L    = 4'd4,
    CLS_DIV_U    = 4'd5,
    CLS_DIV_S    = 4'd6,
    CLS_LS_ONE   = 4'd7,
    CLS_LS_MULTI = 4'd8,
    CLS_BRANCH   = 4'd9
  } cls_e;

  typedef enum logic [1:0] {SCH_ONCE, SCH_TWICE, SCH_DIV_U, SCH_DIV_S} sched_e;

  typedef struct packed {
    logic                 ok;
    logic [NUM_UNITS-1:0] mask;
    sched_e               sched;
  } opt_t;

  // alt = 0 gives the first choice, alt = 1 the fallback
  function automatic opt_t pick_opt(logic [3:0] cls, logic alt);
    opt_t o;
    o.ok    = 1'b0;
    o.mask  = '0;
    o.sched = SCH_ONCE;
    case (cls)
      CLS_ALU: begin
        o.ok   = 1'b1;
        o.mask = alt ? (M_B | M_ALU) : (M_A | M_ALU);
      end
      CLS_ALU_SREG: begin
        o.ok   = 1'b1;
        o.mask = alt ? (M_B | M_C | M_ALU) : (M_A | M_ALU);
      end
      CLS_MOV: begin
        o.ok   = 1'b1;
        o.mask = alt ? (M_B | M_ALU) : M_A;
      end
      CLS_MUL_S: if (!alt) begin
        o.ok = 1'b1; o.mask = M_A | M_ALU;
      end
      CLS_MUL_L: if (!alt) begin
        o.ok = 1'b1; o.mask = M_A | M_ALU; o.sched = SCH_TWICE;
      end
      CLS_DIV_U: if (!alt) begin
        o.ok = 1'b1; o.mask = M_A | M_ALU; o.sched = SCH_DIV_U;
      end
      CLS_DIV_S: if (!alt) begin
        o.ok = 1'b1; o.mask = M_A | M_ALU; o.sched = SCH_DIV_S;
      end
      CLS_LS_ONE: if (!alt) begin
        o.ok = 1'b1; o.mask = M_A | M_C;
      end
      CLS_LS_MULTI: if (!alt) begin
        o.ok = 1'b1; o.mask = M_A | M_B; o.sched = SCH_TWICE;
      end
      CLS_BRANCH: if (!alt) begin
        o.ok = 1'b1; o.mask = M_B;
      end
      default: if (!alt) o.ok = 1'b1;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/issue_slot.sv
module issue_slot
  import dual_issue_pkg::*;
#(
  parameter int DEPTH    = 10,
  parameter int UDIV_GAP = 7,
  parameter int SDIV_GAP = 8
) (
  input  logic                            req_i,
  input  logic [3:0]                      cls_i,
  input  logic [DEPTH-1:0][NUM_UNITS-1:0] occ_i,
  output logic                            grant_o,
  output logic [NUM_UNITS-1:0]            map_o,
  output logic [DEPTH-1:0][NUM_UNITS-1:0] res_o
);

  localparam int NUM_OPT = 2;
  localparam int U_OFF   = UDIV_GAP + 1;
  localparam int S_OFF   = SDIV_GAP + 1;

  function automatic logic [DEPTH-1:0][NUM_UNITS-1:0] expand(logic [NUM_UNITS-1:0] m,
                                                             sched_e s);
    logic [DEPTH-1:0][NUM_UNITS-1:0] e;
    e    = '0;
    e[0] = m;
    case (s)
      SCH_TWICE: e[1]     = m;
      SCH_DIV_U: e[U_OFF] = m;
      SCH_DIV_S: e[S_OFF] = m;
      default: ;
    endcase
    return e;
  endfunction

  opt_t                            opt_c [NUM_OPT];
  logic [DEPTH-1:0][NUM_UNITS-1:0] exp_c [NUM_OPT];
  logic [NUM_OPT-1:0]              fit;

  for (genvar o = 0; o < NUM_OPT; o++) begin : g_opt
    assign opt_c[o] = pick_opt(cls_i, 1'(o));
    assign exp_c[o] = expand(opt_c[o].mask, opt_c[o].sched);
    assign fit[o]   = opt_c[o].ok && ((exp_c[o] & occ_i) == '0);
  end

  always_comb begin
    grant_o = req_i && (fit != '0);
    res_o   = '0;
    if (grant_o) res_o = fit[0] ? exp_c[0] : exp_c[1];
    map_o   = res_o[0];
  end

endmodule

// File: rtl/resv_track.sv
module resv_track
  import dual_issue_pkg::*;
#(
  parameter int DEPTH = 10
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic [DEPTH-1:0][NUM_UNITS-1:0] res_a_i,
  input  logic [DEPTH-1:0][NUM_UNITS-1:0] res_b_i,
  output logic [DEPTH-1:0][NUM_UNITS-1:0] occ_o
);

  logic [DEPTH-1:0][NUM_UNITS-1:0] busy_q, busy_d;

  // entry k = units claimed k cycles from now
  always_comb begin
    busy_d = '0;
    for (int k = 0; k < DEPTH - 1; k++) begin
      busy_d[k] = busy_q[k+1] | res_a_i[k+1] | res_b_i[k+1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= busy_d;
  end

  assign occ_o = busy_q;

  assert_slots_disjoint_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_a_i & res_b_i) == '0);

  assert_no_double_claim_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((res_a_i | res_b_i) & busy_q) == '0);

endmodule

// File: rtl/dual_issue_check.sv
module dual_issue_check
  import dual_issue_pkg::*;
#(
  parameter int UDIV_GAP = 7,
  parameter int SDIV_GAP = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       old_valid_i,
  input  logic [3:0] old_cls_i,
  input  logic       yng_valid_i,
  input  logic [3:0] yng_cls_i,
  input  logic       yng_dep_i,
  output logic       issue_old_o,
  output logic       issue_yng_o,
  output logic [3:0] old_map_o,
  output logic [3:0] yng_map_o
);

  localparam int DEPTH = ((SDIV_GAP > UDIV_GAP) ? SDIV_GAP : UDIV_GAP) + 2;

  logic [DEPTH-1:0][NUM_UNITS-1:0] occ, occ_yng, res_old, res_yng;
  logic                            yng_req, pair_ban;

  resv_track #(.DEPTH(DEPTH)) i_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .res_a_i (res_old),
    .res_b_i (res_yng),
    .occ_o   (occ)
  );

  issue_slot #(.DEPTH(DEPTH), .UDIV_GAP(UDIV_GAP), .SDIV_GAP(SDIV_GAP)) i_slot_old (
    .req_i   (old_valid_i),
    .cls_i   (old_cls_i),
    .occ_i   (occ),
    .grant_o (issue_old_o),
    .map_o   (old_map_o),
    .res_o   (res_old)
  );

  assign pair_ban = (old_cls_i == CLS_MOV) && (yng_cls_i == CLS_ALU);
  assign yng_req  = yng_valid_i && issue_old_o && !yng_dep_i && !pair_ban;
  assign occ_yng  = occ | res_old;

  issue_slot #(.DEPTH(DEPTH), .UDIV_GAP(UDIV_GAP), .SDIV_GAP(SDIV_GAP)) i_slot_yng (
    .req_i   (yng_req),
    .cls_i   (yng_cls_i),
    .occ_i   (occ_yng),
    .grant_o (issue_yng_o),
    .map_o   (yng_map_o),
    .res_o   (res_yng)
  );

  assert_in_order_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_yng_o |-> issue_old_o);

  assert_dep_blocks_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    yng_dep_i |-> !issue_yng_o);

  assert_mov_alu_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (old_cls_i == 4'd2 && yng_cls_i == 4'd0) |-> !issue_yng_o);

  assert_maps_disjoint_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_old_o && issue_yng_o) |-> (old_map_o & yng_map_o) == 4'b0);

  assert_mull_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_old_o && old_cls_i == 4'd4) |=>
      ((old_map_o | yng_map_o) & 4'b1001) == 4'b0);

  assert_branch_free_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (old_valid_i && old_cls_i == 4'd9 && !occ[0][1]) |->
      (issue_old_o && old_map_o == 4'b0010));

  assert_idle_map_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_old_o |-> (old_map_o == 4'b0 && yng_map_o == 4'b0));

endmodule

// File: tb/test_dual_issue_check.sv
`timescale 1ns/1ps
module test_dual_issue_check;

  localparam int UG = 7;
  localparam int SG = 8;
  localparam int MD = 16;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       old_valid, yng_valid, yng_dep;
  logic [3:0] old_cls, yng_cls;
  logic       issue_old, issue_yng;
  logic [3:0] old_map, yng_map;

  int tests = 0;
  int fails = 0;

  logic [3:0] busy  [MD];
  logic [3:0] m_occ [MD];

  always #4 clk = ~clk;

  dual_issue_check #(.UDIV_GAP(UG), .SDIV_GAP(SG)) i_dual_issue_check (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .old_valid_i (old_valid),
    .old_cls_i   (old_cls),
    .yng_valid_i (yng_valid),
    .yng_cls_i   (yng_cls),
    .yng_dep_i   (yng_dep),
    .issue_old_o (issue_old),
    .issue_yng_o (issue_yng),
    .old_map_o   (old_map),
    .yng_map_o   (yng_map)
  );

  // bit4 = option exists, bits 3:0 = unit mask (A=1, B=2, C=4, ALU=8)
  function automatic logic [4:0] choice(int cls, int k);
    if (cls == 0) return (k == 0) ? 5'h19 : 5'h1A;
    if (cls == 1) return (k == 0) ? 5'h19 : 5'h1E;
    if (cls == 2) return (k == 0) ? 5'h11 : 5'h1A;
    if (k != 0)   return 5'h00;
    if (cls >= 3 && cls <= 6) return 5'h19;
    if (cls == 7) return 5'h15;
    if (cls == 8) return 5'h13;
    if (cls == 9) return 5'h12;
    return 5'h10;
  endfunction

  function automatic int later(int cls);
    if (cls == 4 || cls == 8) return 1;
    if (cls == 5) return UG + 1;
    if (cls == 6) return SG + 1;
    return 0;
  endfunction

  task automatic place(input int cls, output bit ok, output logic [3:0] m);
    ok = 1'b0;
    m  = 4'h0;
    for (int k = 0; k < 2; k++) begin
      logic [4:0] c;
      int         l;
      c = choice(cls, k);
      l = later(cls);
      if (!ok && c[4] && (m_occ[0] & c[3:0]) == 4'h0 &&
          (l == 0 || (m_occ[l] & c[3:0]) == 4'h0)) begin
        ok = 1'b1;
        m  = c[3:0];
        m_occ[0] = m_occ[0] | m;
        if (l != 0) m_occ[l] = m_occ[l] | m;
      end
    end
  endtask

  task automatic step(input bit vo, input int co, input bit vy, input int cy,
                      input bit dp, input string tag);
    bit         eo, ey;
    logic [3:0] mo, my;
    logic [9:0] act, exp_v;
    @(negedge clk);
    old_valid = vo; old_cls = 4'(co);
    yng_valid = vy; yng_cls = 4'(cy); yng_dep = dp;
    #1;
    for (int k = 0; k < MD; k++) m_occ[k] = busy[k];
    eo = 1'b0; ey = 1'b0; mo = 4'h0; my = 4'h0;
    if (vo && rst_ni) place(co, eo, mo);
    if (eo && vy && !dp && !(co == 2 && cy == 0)) place(cy, ey, my);
    exp_v = {eo, ey, mo, my};
    act   = {issue_old, issue_yng, old_map, yng_map};
    tests++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: {iss_old,iss_yng,map_old,map_yng} got %b expected %b (cls %0d/%0d)",
               tag, act, exp_v, co, cy);
    end
    if (rst_ni) begin
      for (int k = 0; k < MD - 1; k++) busy[k] = m_occ[k+1];
      busy[MD-1] = 4'h0;
    end
  endtask

  initial begin
    #(8.0 * 200000);
    fails++;
    tests++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < MD; k++) busy[k] = 4'h0;
    old_valid = 0; yng_valid = 0; yng_dep = 0; old_cls = 0; yng_cls = 0;
    // R1: outputs idle during and after reset
    step(0, 0, 0, 0, 0, "R1");
    @(negedge clk); rst_ni = 1'b1;
    step(0, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 0, "R1");
    // R2: first choice, then fallback B+ALU behind a single load/store
    step(1, 0, 1, 0, 0, "R2");
    step(1, 7, 1, 0, 0, "R2");
    // R3: fallback B+C+ALU behind a move, first choice behind a branch
    step(1, 2, 1, 1, 0, "R3");
    step(1, 9, 1, 1, 0, "R3");
    step(1, 7, 1, 1, 0, "R3");
    // R4: move alone, move pair, move behind ALU
    step(1, 2, 1, 2, 0, "R4");
    step(1, 0, 1, 2, 0, "R4");
    // R5: short and long multiply followed by ALU work
    step(1, 3, 0, 0, 0, "R5");
    step(1, 0, 0, 0, 0, "R5");
    step(1, 4, 0, 0, 0, "R5");
    step(1, 0, 1, 9, 0, "R5");
    step(1, 0, 0, 0, 0, "R5");
    // R6: unsigned divide then moves across the whole window
    step(1, 5, 0, 0, 0, "R6");
    for (int i = 0; i < 10; i++) step(1, 2, 0, 0, 0, "R6");
    step(1, 6, 0, 0, 0, "R6");
    for (int i = 0; i < 11; i++) step(1, 0, 1, 9, 0, "R6");
    // R7: single and multi-word memory access
    step(1, 7, 1, 9, 0, "R7");
    step(1, 8, 1, 0, 0, "R7");
    step(1, 9, 0, 0, 0, "R7");
    step(1, 9, 0, 0, 0, "R7");
    // R8: branch with ALU, codes that take no unit
    step(1, 9, 1, 0, 0, "R8");
    step(1, 12, 1, 15, 0, "R8");
    step(1, 4, 1, 10, 0, "R8");
    step(1, 11, 1, 0, 0, "R8");
    // R9: pairing bans
    step(1, 7, 1, 0, 1, "R9");
    step(1, 2, 1, 0, 0, "R9");
    step(0, 0, 1, 9, 0, "R9");
    // R10: younger limited to leftover units
    step(1, 1, 1, 1, 0, "R10");
    step(1, 9, 1, 8, 0, "R10");
    // R11: stall on carried reservation
    step(1, 8, 0, 0, 0, "R11");
    step(1, 7, 1, 9, 0, "R11");
    step(1, 7, 1, 9, 0, "R11");
    // mixed stream against the model
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 8) != 0, int'($urandom % 12), ($urandom % 4) != 0,
           int'($urandom % 12), ($urandom % 5) == 0, "R10");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule